// File: doc/BRIEF.md
# Push-Button Volume Step Controller

This block turns three active-low push buttons (louder, quieter, mute) and an active-low standby request into a shared attenuation level for a stereo volume stage. Each button is filtered so that short glitches cannot move the level. A held louder or quieter button produces further steps on its own, first at a slow rate and then at a faster one. A short lockout follows every accepted press, and any press that overlaps another button is thrown away. The block never drives a resistor ladder itself. For each accepted change it puts out a one-cycle strobe together with the new target level. It waits for the downstream stage to report that the change has been applied, and only then updates its own committed level.

All time constants are counted in pulses of a `tick` enable rather than in clock cycles. A real design feeds one tick per millisecond. A testbench can feed ticks quickly and use small constants.

Level codes on `cmd_lvl` and `cur_lvl`:
- 0 to 2^IDX_W-1 are attenuation indices. Index 0 is the loudest and the top index is the quietest.
- 2^IDX_W (32 by default) is the mute code.
- 2^IDX_W+1 (33 by default) is the standby park code.

All inputs must be synchronous to `clk`.

Top module: `vol_step_ctrl`

## Requirements
- R1: After reset, `cur_lvl` and `cmd_lvl` both equal RST_IDX (10 by default) and `cmd_stb` is low.
- R2: A button press takes effect only after the input has stayed low for DB_TICKS consecutive ticks. A low pulse that lasts fewer ticks changes nothing.
- R3: An accepted louder press (bit `up_n`) issues one strobe with the committed index minus one. An accepted quieter press (`dn_n`) issues one strobe with the index plus one. `cmd_stb` is high for exactly one cycle.
- R4: While a louder or quieter button stays held, extra steps occur at the following times, counted in ticks after acceptance: HOLD_TICKS, then every SLOW_PER for SLOW_STEPS steps, then every FAST_PER until the button is released. A repeat step that falls while a command is still unacknowledged is dropped.
- R5: The index saturates. A louder step at index 0 and a quieter step at the top index are ignored and issue no strobe.
- R6: For LOCK_TICKS ticks after an accepted press, any new press is ignored.
- R7: From the moment two or more buttons are low at once until all three are high again, no press is accepted and auto-repeat stops.
- R8: A mute press toggles between the mute code (32) and the saved index. Louder and quieter presses are ignored while muted.
- R9: While `sby_n` is low, the block issues the park code (33) and ignores every button. When `sby_n` goes high, it restores the previous level (the index or the mute code).
- R10: `cur_lvl` changes only in the cycle after `apply_ack` is high while a command is pending. No new strobe is issued until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base enable, one pulse per time unit |
| up_n | input | 1 | Louder button, active low |
| dn_n | input | 1 | Quieter button, active low |
| mute_n | input | 1 | Mute toggle button, active low |
| sby_n | input | 1 | Standby request, active low |
| apply_ack | input | 1 | Downstream reports that the last target was applied |
| cmd_stb | output | 1 | One-cycle strobe for a new target |
| cmd_lvl | output | IDX_W+1 | Target level code of the latest strobe |
| cur_lvl | output | IDX_W+1 | Committed level code |

## Verification
A wrong debounce count or lockout value would show up as a strobe appearing one or more ticks too early or too late, so the bench compares `cmd_stb` on every clock against a reference that models time as elapsed ticks. A corrupted saved index or mute/park flag would appear on `cmd_lvl` at the next strobe, and on `cur_lvl` one cycle after the matching acknowledge. A broken repeat phase would appear as steps at the wrong tick counts within a few ticks of the phase change.

// File: rtl/vstep_pkg.sv
package vstep_pkg;
  localparam int N_BTN   = 3;
  localparam int BTN_UP  = 0;
  localparam int BTN_DN  = 1;
  localparam int BTN_MUT = 2;

  typedef enum logic [1:0] {RP_OFF, RP_WAIT, RP_SLOW, RP_FAST} rep_ph_t;
endpackage

// File: rtl/vstep_debounce.sv
module vstep_debounce #(
  parameter int DB_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw_n,
  output logic take,
  output logic held
);
  localparam int CW = $clog2(DB_TICKS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                              cnt <= '0;
    else if (raw_n)                          cnt <= '0;
    else if (tick && cnt != CW'(DB_TICKS))   cnt <= cnt + 1'b1;
  end

  assign held = !raw_n;
  // single pulse on the tick that completes the low interval
  assign take = !raw_n && tick && (cnt == CW'(DB_TICKS - 1));
endmodule

// File: rtl/vstep_repeat.sv
module vstep_repeat #(
  parameter int HOLD_TICKS = 1000,
  parameter int SLOW_PER   = 250,
  parameter int SLOW_STEPS = 16,
  parameter int FAST_PER   = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic start,
  input  logic keep,
  output logic fire
);
  import vstep_pkg::*;

  localparam int PMAX = (HOLD_TICKS > SLOW_PER) ?
                        ((HOLD_TICKS > FAST_PER) ? HOLD_TICKS : FAST_PER) :
                        ((SLOW_PER > FAST_PER) ? SLOW_PER : FAST_PER);
  localparam int CW = $clog2(PMAX + 1);
  localparam int NW = $clog2(SLOW_STEPS + 1);

  rep_ph_t       ph;
  logic [CW-1:0] cnt;
  logic [NW-1:0] nslow;
  logic [CW-1:0] per;

  always_comb begin
    case (ph)
      RP_WAIT: per = CW'(HOLD_TICKS);
      RP_SLOW: per = CW'(SLOW_PER);
      default: per = CW'(FAST_PER);
    endcase
  end

  assign fire = (ph != RP_OFF) && keep && tick && (cnt == per - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= RP_OFF; cnt <= '0; nslow <= '0;
    end else if (start) begin
      ph <= RP_WAIT; cnt <= '0; nslow <= '0;
    end else if (ph != RP_OFF && !keep) begin
      ph <= RP_OFF;
    end else if (fire) begin
      cnt <= '0;
      case (ph)
        RP_WAIT: begin ph <= RP_SLOW; nslow <= '0; end
        RP_SLOW: begin
          if (nslow == NW'(SLOW_STEPS - 1)) ph <= RP_FAST;
          else                               nslow <= nslow + 1'b1;
        end
        default: ;
      endcase
    end else if (ph != RP_OFF && tick) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/vol_step_ctrl.sv
module vol_step_ctrl #(
  parameter int IDX_W      = 5,
  parameter int RST_IDX    = 10,
  parameter int DB_TICKS   = 50,
  parameter int LOCK_TICKS = 40,
  parameter int HOLD_TICKS = 1000,
  parameter int SLOW_PER   = 250,
  parameter int SLOW_STEPS = 16,
  parameter int FAST_PER   = 125
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             up_n,
  input  logic             dn_n,
  input  logic             mute_n,
  input  logic             sby_n,
  input  logic             apply_ack,
  output logic             cmd_stb,
  output logic [IDX_W:0]   cmd_lvl,
  output logic [IDX_W:0]   cur_lvl
);
  localparam int NB    = vstep_pkg::N_BTN;
  localparam int B_UP  = vstep_pkg::BTN_UP;
  localparam int B_DN  = vstep_pkg::BTN_DN;
  localparam int LVL_W = IDX_W + 1;
  localparam int LW    = $clog2(LOCK_TICKS + 1);
  localparam logic [IDX_W-1:0] IDX_MAX  = '1;
  localparam logic [LVL_W-1:0] LVL_MUTE = LVL_W'(2 ** IDX_W);
  localparam logic [LVL_W-1:0] LVL_PARK = LVL_W'(2 ** IDX_W + 1);

  function automatic logic [LVL_W-1:0] lvl_code(input logic [IDX_W-1:0] v,
                                                 input logic m, input logic p);
    if (p) return LVL_PARK;
    if (m) return LVL_MUTE;
    return {1'b0, v};
  endfunction

  function automatic logic [1:0] low_count(input logic [NB-1:0] lo);
    return 2'(lo[0]) + 2'(lo[1]) + 2'(lo[2]);
  endfunction

  // button filters: bit 0 louder, bit 1 quieter, bit 2 mute
  logic [NB-1:0] btn_n, take, held;
  assign btn_n = {mute_n, dn_n, up_n};

  for (genvar b = 0; b < NB; b++) begin : g_db
    vstep_debounce #(.DB_TICKS(DB_TICKS)) u_db (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .raw_n(btn_n[b]), .take(take[b]), .held(held[b]));
  end

  // overlap tracking
  logic clash, clash_flag, any_low;
  assign clash_flag = clash || (low_count(held) >= 2'd2);
  assign any_low    = |held;

  always_ff @(posedge clk) begin
    if (!rst_n)              clash <= 1'b0;
    else if (!any_low)       clash <= 1'b0;
    else if (clash_flag)     clash <= 1'b1;
  end

  // committed and pending state
  logic [IDX_W-1:0] vol, p_vol, n_vol;
  logic             muted, parked, p_mut, p_prk, n_mut, n_prk, pend;
  logic [LW-1:0]    lock;
  logic             lock_active, rep_up, rep_fire, rep_keep;
  logic             issue, arm_lock, rep_start, rep_dir_up;
  logic             idle, gate_btn, press_take, up_ok, dn_ok;

  assign lock_active = (lock != '0);
  assign idle        = !pend;
  assign gate_btn    = idle && sby_n && !parked;
  assign press_take  = gate_btn && (|take) && !clash_flag && !lock_active;
  assign up_ok       = !muted && (vol != '0);
  assign dn_ok       = !muted && (vol != IDX_MAX);
  assign rep_keep    = (rep_up ? held[B_UP] : held[B_DN]) && !clash_flag;

  vstep_repeat #(
    .HOLD_TICKS(HOLD_TICKS), .SLOW_PER(SLOW_PER),
    .SLOW_STEPS(SLOW_STEPS), .FAST_PER(FAST_PER)
  ) u_rep (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .start(rep_start), .keep(rep_keep), .fire(rep_fire));

  always_comb begin
    n_vol = vol; n_mut = muted; n_prk = parked;
    issue = 1'b0; arm_lock = 1'b0; rep_start = 1'b0; rep_dir_up = rep_up;
    if (idle && !sby_n && !parked) begin
      n_prk = 1'b1; issue = 1'b1;
    end else if (idle && sby_n && parked) begin
      n_prk = 1'b0; issue = 1'b1;
    end else if (press_take) begin
      if (take[B_UP]) begin
        if (up_ok) begin
          n_vol = vol - 1'b1; issue = 1'b1; arm_lock = 1'b1;
          rep_start = 1'b1; rep_dir_up = 1'b1;
        end
      end else if (take[B_DN]) begin
        if (dn_ok) begin
          n_vol = vol + 1'b1; issue = 1'b1; arm_lock = 1'b1;
          rep_start = 1'b1; rep_dir_up = 1'b0;
        end
      end else begin
        n_mut = !muted; issue = 1'b1; arm_lock = 1'b1;
      end
    end else if (gate_btn && rep_fire && !muted) begin
      if (rep_up && vol != '0) begin
        n_vol = vol - 1'b1; issue = 1'b1;
      end else if (!rep_up && vol != IDX_MAX) begin
        n_vol = vol + 1'b1; issue = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vol <= IDX_W'(RST_IDX); muted <= 1'b0; parked <= 1'b0;
      p_vol <= IDX_W'(RST_IDX); p_mut <= 1'b0; p_prk <= 1'b0;
      pend <= 1'b0; lock <= '0; rep_up <= 1'b1;
      cmd_stb <= 1'b0; cmd_lvl <= LVL_W'(RST_IDX);
    end else begin
      cmd_stb <= issue;
      if (issue) cmd_lvl <= lvl_code(n_vol, n_mut, n_prk);
      if (rep_start) rep_up <= rep_dir_up;
      if (arm_lock)                 lock <= LW'(LOCK_TICKS);
      else if (tick && lock_active) lock <= lock - 1'b1;
      if (pend && apply_ack) begin
        vol <= p_vol; muted <= p_mut; parked <= p_prk; pend <= 1'b0;
      end else if (issue) begin
        p_vol <= n_vol; p_mut <= n_mut; p_prk <= n_prk; pend <= 1'b1;
      end
    end
  end

  assign cur_lvl = lvl_code(vol, muted, parked);
endmodule

// File: rtl/vol_step_chk.sv
module vol_step_chk #(
  parameter int IDX_W = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sby_n,
  input logic           apply_ack,
  input logic           cmd_stb,
  input logic [IDX_W:0] cmd_lvl,
  input logic [IDX_W:0] cur_lvl,
  input logic           press_take,
  input logic           any_low
);
  localparam int MUTE_C = 2 ** IDX_W;
  localparam int PARK_C = 2 ** IDX_W + 1;

  // R2: an accepted press needs the button already low on the previous cycle
  p_filtered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    press_take |-> $past(any_low));

  // R3: a plain index change moves by exactly one
  p_unit_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && int'(cmd_lvl) < MUTE_C && int'(cur_lvl) < MUTE_C) |->
      (int'(cmd_lvl) == int'(cur_lvl) + 1 || int'(cur_lvl) == int'(cmd_lvl) + 1));

  // R8: leaving mute with standby released can only go to an index
  p_mute_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && sby_n && int'(cur_lvl) == MUTE_C) |-> int'(cmd_lvl) < MUTE_C);

  // R9: during standby every strobe carries the park code
  p_park_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stb && !sby_n) |-> int'(cmd_lvl) == PARK_C);

  // R10: a strobe is never followed at once by another
  p_one_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |=> !cmd_stb);

  // R10: the committed level only moves after an acknowledge
  p_commit_on_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !apply_ack |=> $stable(cur_lvl));
endmodule

bind vol_step_ctrl vol_step_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sby_n(sby_n), .apply_ack(apply_ack),
  .cmd_stb(cmd_stb), .cmd_lvl(cmd_lvl), .cur_lvl(cur_lvl),
  .press_take(press_take), .any_low(any_low));

// File: tb/tb_vol_step_ctrl.sv
module tb_vol_step_ctrl;
  localparam int IDX_W = 5, RST_IDX = 10, DB = 4, LOCK = 10;
  localparam int HOLD = 20, SP = 5, SN = 3, FP = 2, ACK_DLY = 3;
  localparam int MUTE_C = 32, PARK_C = 33, TOPI = 31;

  logic clk = 0, rst_n = 0, tick = 0;
  logic up_n = 1, dn_n = 1, mute_n = 1, sby_n = 1;
  logic ack_auto_q = 0, ack_man = 0, ack_en = 1;
  logic apply_ack;
  logic cmd_stb;
  logic [IDX_W:0] cmd_lvl, cur_lvl;

  assign apply_ack = ack_auto_q | ack_man;

  vol_step_ctrl #(.IDX_W(IDX_W), .RST_IDX(RST_IDX), .DB_TICKS(DB),
    .LOCK_TICKS(LOCK), .HOLD_TICKS(HOLD), .SLOW_PER(SP),
    .SLOW_STEPS(SN), .FAST_PER(FP)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .up_n(up_n), .dn_n(dn_n),
    .mute_n(mute_n), .sby_n(sby_n), .apply_ack(apply_ack),
    .cmd_stb(cmd_stb), .cmd_lvl(cmd_lvl), .cur_lvl(cur_lvl));

  always #2 clk = ~clk;

  int n_chk = 0, n_err = 0, n_stb = 0, ack_wait = 0;
  string cur_req = "R1";
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // time base and downstream acknowledge
  always @(negedge clk) begin
    tick = ~tick;
    ack_auto_q = 0;
    if (ack_wait > 0) begin
      ack_wait--;
      if (ack_wait == 0) ack_auto_q = 1;
    end else if (cmd_stb && ack_en) ack_wait = ACK_DLY;
    if (rst_n && cmd_stb) n_stb++;
  end

  // ---------------- reference model: elapsed-tick view ----------------
  int  m_low[3];
  int  m_lock, m_vol, m_pv, m_rep_t, m_cmd;
  bit  m_clash, m_mu, m_pk, m_pend, m_pm, m_pp, m_stb, m_rep_on, m_rep_up;

  function automatic int enc(int v, bit m, bit p);
    return p ? PARK_C : (m ? MUTE_C : v);
  endfunction

  function automatic bit due(int t);
    if (t == HOLD) return 1;
    if (t > HOLD && t <= HOLD + SN*SP) return ((t - HOLD) % SP) == 0;
    if (t > HOLD + SN*SP) return ((t - HOLD - SN*SP) % FP) == 0;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_low[i]) m_low[i] = 0;
      m_lock = 0; m_vol = RST_IDX; m_pv = RST_IDX; m_cmd = RST_IDX;
      m_clash = 0; m_mu = 0; m_pk = 0; m_pend = 0; m_pm = 0; m_pp = 0;
      m_stb = 0; m_rep_on = 0; m_rep_up = 1; m_rep_t = 0;
    end else begin
      bit lo[3];
      bit hit[3];
      bit overlap, keep, fire, go, arm, start, sdir, btn_ok;
      int nv; bit nm, np;
      lo[0] = !up_n; lo[1] = !dn_n; lo[2] = !mute_n;
      overlap = m_clash || (int'(lo[0]) + int'(lo[1]) + int'(lo[2]) >= 2);
      for (int b = 0; b < 3; b++) hit[b] = lo[b] && tick && (m_low[b] + 1 == DB);
      keep = m_rep_on && (m_rep_up ? lo[0] : lo[1]) && !overlap;
      fire = keep && tick && due(m_rep_t + 1);
      btn_ok = !m_pend && sby_n && !m_pk;
      nv = m_vol; nm = m_mu; np = m_pk; go = 0; arm = 0; start = 0; sdir = m_rep_up;
      if (!m_pend && !sby_n && !m_pk) begin np = 1; go = 1; end
      else if (!m_pend && sby_n && m_pk) begin np = 0; go = 1; end
      else if (btn_ok && (hit[0] || hit[1] || hit[2]) && !overlap && m_lock == 0) begin
        if (hit[0]) begin
          if (!m_mu && m_vol > 0) begin nv = m_vol - 1; go = 1; arm = 1; start = 1; sdir = 1; end
        end else if (hit[1]) begin
          if (!m_mu && m_vol < TOPI) begin nv = m_vol + 1; go = 1; arm = 1; start = 1; sdir = 0; end
        end else begin nm = !m_mu; go = 1; arm = 1; end
      end else if (btn_ok && fire && !m_mu) begin
        if (m_rep_up && m_vol > 0) begin nv = m_vol - 1; go = 1; end
        else if (!m_rep_up && m_vol < TOPI) begin nv = m_vol + 1; go = 1; end
      end
      // state advance
      for (int b = 0; b < 3; b++) m_low[b] = lo[b] ? m_low[b] + int'(tick) : 0;
      if (!(lo[0] || lo[1] || lo[2])) m_clash = 0; else if (overlap) m_clash = 1;
      if (arm) m_lock = LOCK; else if (tick && m_lock > 0) m_lock--;
      if (start) begin m_rep_on = 1; m_rep_t = 0; m_rep_up = sdir; end
      else if (m_rep_on && !keep) m_rep_on = 0;
      else if (m_rep_on && tick) m_rep_t++;
      m_stb = go;
      if (go) m_cmd = enc(nv, nm, np);
      if (m_pend && apply_ack) begin m_vol = m_pv; m_mu = m_pm; m_pk = m_pp; m_pend = 0; end
      else if (go) begin m_pv = nv; m_pm = nm; m_pp = np; m_pend = 1; end
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({cur_req, " strobe"}, int'(cmd_stb), int'(m_stb));
      chk({cur_req, " target"}, int'(cmd_lvl), m_cmd);
      chk({cur_req, " level"},  int'(cur_lvl), enc(m_vol, m_mu, m_pk));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_btn(input int b, input logic v);
    case (b)
      0: up_n = v;
      1: dn_n = v;
      default: mute_n = v;
    endcase
  endtask

  task automatic press(input int b, input int cyc);
    set_btn(b, 0); wait_cyc(cyc); set_btn(b, 1); wait_cyc(40);
  endtask

  int s0;

  initial begin
    wait_cyc(4);
    rst_n = 1;
    wait_cyc(1);
    cur_req = "R1";
    chk("R1 reset level", int'(cur_lvl), RST_IDX);
    chk("R1 reset target", int'(cmd_lvl), RST_IDX);
    chk("R1 reset strobe", int'(cmd_stb), 0);

    cur_req = "R2";
    press(0, 3);
    chk("R2 short pulse ignored", int'(cur_lvl), 10);

    cur_req = "R3";
    press(0, 12);
    chk("R3 louder step", int'(cur_lvl), 9);
    press(1, 12);
    chk("R3 quieter step", int'(cur_lvl), 10);

    cur_req = "R6";
    set_btn(0, 0); wait_cyc(12); set_btn(0, 1); wait_cyc(2);
    press(0, 12);
    chk("R6 press inside lockout ignored", int'(cur_lvl), 9);
    press(0, 12);
    chk("R6 press after lockout", int'(cur_lvl), 8);

    cur_req = "R4";
    press(1, 70);
    chk("R4 held button repeats", int'(cur_lvl >= 11), 1);

    cur_req = "R5";
    press(1, 400);
    chk("R5 saturate quiet end", int'(cur_lvl), TOPI);
    s0 = n_stb;
    press(1, 12);
    chk("R5 quieter at end no strobe", n_stb - s0, 0);
    press(0, 600);
    chk("R5 saturate loud end", int'(cur_lvl), 0);
    s0 = n_stb;
    press(0, 12);
    chk("R5 louder at end no strobe", n_stb - s0, 0);

    cur_req = "R7";
    s0 = n_stb;
    dn_n = 0; mute_n = 0; wait_cyc(20); dn_n = 1; mute_n = 1; wait_cyc(40);
    chk("R7 overlapping press discarded", n_stb - s0, 0);
    chk("R7 level kept", int'(cur_lvl), 0);

    cur_req = "R8";
    press(1, 12);
    press(2, 12);
    chk("R8 mute code", int'(cur_lvl), MUTE_C);
    press(1, 12);
    chk("R8 quieter ignored while muted", int'(cur_lvl), MUTE_C);
    press(2, 12);
    chk("R8 unmute restores", int'(cur_lvl), 1);

    cur_req = "R9";
    sby_n = 0; wait_cyc(20);
    chk("R9 park code", int'(cur_lvl), PARK_C);
    press(1, 12);
    chk("R9 button ignored in standby", int'(cur_lvl), PARK_C);
    sby_n = 1; wait_cyc(20);
    chk("R9 restore index", int'(cur_lvl), 1);
    press(2, 12);
    sby_n = 0; wait_cyc(20);
    chk("R9 park while muted", int'(cur_lvl), PARK_C);
    sby_n = 1; wait_cyc(20);
    chk("R9 restore mute", int'(cur_lvl), MUTE_C);
    press(2, 12);
    chk("R9 unmute after standby", int'(cur_lvl), 1);

    cur_req = "R10";
    ack_en = 0;
    s0 = n_stb;
    press(1, 12);
    chk("R10 target issued", int'(cmd_lvl), 2);
    chk("R10 level held without ack", int'(cur_lvl), 1);
    press(1, 12);
    chk("R10 no strobe while pending", n_stb - s0, 1);
    ack_man = 1; wait_cyc(1); ack_man = 0;
    chk("R10 level after ack", int'(cur_lvl), 2);
    ack_en = 1;
    press(1, 12);
    chk("R10 normal step resumes", int'(cur_lvl), 3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule